// File: doc/BRIEF.md
# Bidirectional Cascadable Column Load Sequencer

This block decides which column position of a display row receives each incoming pixel word. A start token arms it. From then on, every sampling edge with a valid pixel strobe writes one position and moves a pointer one step. The pointer covers 128 positions, one for each RGB triplet, so it spans 384 output columns. When the last position has been written, the block falls back to standby. In standby it ignores clock and data until the next start token arrives.

Several devices can be chained so that they fill a wider row. The direction select chooses three things together: which of the two start-token ports is the input, which is the output, and whether positions fill upward or downward. In a chain, the device that is filling emits a one-cycle token on its output port at the same time as its final write. The next device captures that token on the same sampling edge, so its first write lands in the slot straight after the last slot of the device before it.

A rising edge on the line-latch strobe clears the sequencer back to standby. The `shift_clk` input is the sequencer's sampling edge, which is the falling edge of the external shift clock.

Top module: `col_load_seq`

## Requirements
- R1: While `rst_n` is low and after reset is released, `wr_en` is all zero and both token outputs are low until a token arrives.
- R2: A rising level on the input-side token port is captured on a sampling edge. The first write enable can appear only in the cycle after that edge, when `pix_valid` is high. It addresses position 0 when `dir_fwd`=1 and position NUM_POS-1 when `dir_fwd`=0.
- R3: With `dir_fwd`=1, each cycle with `pix_valid` high writes the next higher position. A cycle with `pix_valid` low produces no write enable and leaves the pointer where it is.
- R4: With `dir_fwd`=0, successive writes go to successively lower positions, from NUM_POS-1 down to 0.
- R5: After the final position is written, no write enable is produced for any `pix_valid` pattern until a new token rising edge arrives.
- R6: The outgoing token is high for exactly the cycle of the final write. It appears on `tok_b_out` when `dir_fwd`=1 and on `tok_a_out` when `dir_fwd`=0, and the other output stays low.
- R7: `tok_b_oe`=1 and `tok_a_oe`=0 when `dir_fwd`=1; the reverse holds when `dir_fwd`=0. A token on the output-side port has no effect.
- R8: A rising edge on `line_latch` returns the block to standby at that sampling edge, so write enables stop from the next cycle on. It takes priority over a token captured on the same edge.
- R9: A token held high for several cycles arms the block only once. A fresh token rising edge during loading restarts at the start position.
- R10: `wr_en` has at most one bit set, and only while loading.
- R11: The stepping direction is fixed when the token is captured. Changing `dir_fwd` during a load does not alter the order of the remaining writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Sampling clock (falling edge of the external shift clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | 1: upward fill, port A in, port B out; 0: downward fill, port B in, port A out |
| tok_a_in | input | 1 | Token level seen on port A |
| tok_a_out | output | 1 | Token driven on port A |
| tok_a_oe | output | 1 | Output enable for port A |
| tok_b_in | input | 1 | Token level seen on port B |
| tok_b_out | output | 1 | Token driven on port B |
| tok_b_oe | output | 1 | Output enable for port B |
| pix_valid | input | 1 | A pixel word is present this cycle |
| line_latch | input | 1 | Line-latch strobe; its rising edge clears the sequencer |
| wr_en | output | NUM_POS | One-hot write enable per column position |

## Verification
On every cycle, the assertions check the one-hot write enables and that no enable appears outside loading. They also check how the pointer steps or holds, the arming position after a captured token, the clear on a line-latch edge, and the fall to standby after the final write. They also check that the outgoing token coincides with the final write and that the two output enables are exclusive. What only the bench scenarios can show is the complete fill order in both directions, the gaps in `pix_valid`, and the cascade timing of the outgoing token. The same goes for the fact that a wrong-port token, a held token or a direction change mid-load leaves the observed write sequence as required.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;
  typedef enum logic {SEQ_STANDBY = 1'b0, SEQ_LOAD = 1'b1} seq_state_e;
endpackage

// File: rtl/seq_rise_det.sv
module seq_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R9: a level held high produces a single rise event
  a_r9_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/col_pointer.sv
module col_pointer
  import col_seq_pkg::*;
#(
  parameter int NUM_POS = 128,
  localparam int PTR_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_sel,
  input  logic             tok_rise,
  input  logic             latch_rise,
  input  logic             pix_valid,
  output logic             loading,
  output logic [PTR_W-1:0] ptr,
  output logic             last_write
);
  localparam logic [PTR_W-1:0] LAST_POS = PTR_W'(NUM_POS - 1);

  function automatic logic [PTR_W-1:0] start_pos(input logic fwd);
    return fwd ? '0 : LAST_POS;
  endfunction

  function automatic logic [PTR_W-1:0] final_pos(input logic fwd);
    return fwd ? LAST_POS : '0;
  endfunction

  function automatic logic [PTR_W-1:0] step_pos(input logic [PTR_W-1:0] p, input logic fwd);
    return fwd ? p + 1'b1 : p - 1'b1;
  endfunction

  seq_state_e state_q;
  logic       dir_q;
  logic       advance;

  assign loading    = (state_q == SEQ_LOAD);
  assign advance    = loading & pix_valid;
  assign last_write = advance & (ptr == final_pos(dir_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_STANDBY;
      ptr     <= '0;
      dir_q   <= 1'b1;
    end else if (latch_rise) begin
      state_q <= SEQ_STANDBY;
      ptr     <= '0;
    end else if (tok_rise) begin
      state_q <= SEQ_LOAD;
      dir_q   <= dir_sel;
      ptr     <= start_pos(dir_sel);
    end else if (advance) begin
      if (last_write) state_q <= SEQ_STANDBY;
      else            ptr     <= step_pos(ptr, dir_q);
    end
  end

  a_r2_arm_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_rise && !latch_rise) |=> (loading && ptr == ($past(dir_sel) ? '0 : LAST_POS)));
  a_r8_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise |=> !loading);
  a_r5_standby_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_write && !tok_rise && !latch_rise) |=> !loading);
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last_write && !tok_rise && !latch_rise) |=>
      (loading && (dir_q ? ptr == $past(ptr) + 1'b1 : ptr == $past(ptr) - 1'b1)));
  a_r3_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !pix_valid && !tok_rise && !latch_rise) |=> (loading && $stable(ptr)));
  a_r11_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !tok_rise) |=> $stable(dir_q));
endmodule

// File: rtl/col_decode.sv
module col_decode #(
  parameter int NUM_POS = 128,
  localparam int PTR_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PTR_W-1:0]   ptr,
  output logic [NUM_POS-1:0] wr_en
);
  for (genvar i = 0; i < NUM_POS; i++) begin : g_pos
    assign wr_en[i] = en & (ptr == PTR_W'(i));
  end

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  a_r10_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> en);
endmodule

// File: rtl/col_load_seq.sv
module col_load_seq #(
  parameter int NUM_POS = 128
) (
  input  logic               shift_clk,
  input  logic               rst_n,
  input  logic               dir_fwd,
  input  logic               tok_a_in,
  output logic               tok_a_out,
  output logic               tok_a_oe,
  input  logic               tok_b_in,
  output logic               tok_b_out,
  output logic               tok_b_oe,
  input  logic               pix_valid,
  input  logic               line_latch,
  output logic [NUM_POS-1:0] wr_en
);
  localparam int PTR_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1;

  logic             tok_in_sel;
  logic             tok_rise;
  logic             latch_rise;
  logic             loading;
  logic             last_write;
  logic [PTR_W-1:0] ptr;

  assign tok_in_sel = dir_fwd ? tok_a_in : tok_b_in;

  seq_rise_det u_tok_rise (
    .clk(shift_clk), .rst_n(rst_n), .lvl(tok_in_sel), .rise(tok_rise)
  );

  seq_rise_det u_latch_rise (
    .clk(shift_clk), .rst_n(rst_n), .lvl(line_latch), .rise(latch_rise)
  );

  col_pointer #(.NUM_POS(NUM_POS)) u_ptr (
    .clk(shift_clk), .rst_n(rst_n), .dir_sel(dir_fwd),
    .tok_rise(tok_rise), .latch_rise(latch_rise), .pix_valid(pix_valid),
    .loading(loading), .ptr(ptr), .last_write(last_write)
  );

  col_decode #(.NUM_POS(NUM_POS)) u_dec (
    .clk(shift_clk), .rst_n(rst_n), .en(loading & pix_valid),
    .ptr(ptr), .wr_en(wr_en)
  );

  assign tok_a_oe  = ~dir_fwd;
  assign tok_b_oe  = dir_fwd;
  assign tok_a_out = ~dir_fwd & last_write;
  assign tok_b_out = dir_fwd & last_write;

  // R6: outgoing token only together with a write enable
  a_r6_tok_with_write: assert property (@(posedge shift_clk) disable iff (!rst_n)
    (tok_a_out || tok_b_out) |-> (|wr_en));
  // R7: exactly one port is driven at a time
  a_r7_oe_exclusive: assert property (@(posedge shift_clk) disable iff (!rst_n)
    (tok_a_oe ^ tok_b_oe) && !(tok_a_out && tok_b_out));
endmodule

// File: tb/col_load_seq_test.sv
module col_load_seq_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir_fwd = 1'b1;
  logic         tok_a_in = 1'b0, tok_b_in = 1'b0;
  logic         pix_valid = 1'b0, line_latch = 1'b0;
  logic         tok_a_out, tok_a_oe, tok_b_out, tok_b_oe;
  logic [N-1:0] wr_en;
  int           n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  col_load_seq #(.NUM_POS(N)) uut (
    .shift_clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
    .tok_a_in(tok_a_in), .tok_a_out(tok_a_out), .tok_a_oe(tok_a_oe),
    .tok_b_in(tok_b_in), .tok_b_out(tok_b_out), .tok_b_oe(tok_b_oe),
    .pix_valid(pix_valid), .line_latch(line_latch), .wr_en(wr_en)
  );

  task automatic cyc(input logic ta, input logic tb, input logic pv, input logic ll);
    @(negedge clk);
    tok_a_in = ta; tok_b_in = tb; pix_valid = pv; line_latch = ll;
    #2;
  endtask

  task automatic chk(input string req, input logic [N-1:0] exp_wr,
                     input logic exp_a, input logic exp_b);
    n_run++;
    if (wr_en !== exp_wr || tok_a_out !== exp_a || tok_b_out !== exp_b) begin
      n_fail++;
      $display("FAIL %s: wr_en=%b a=%b b=%b expected wr_en=%b a=%b b=%b",
               req, wr_en, tok_a_out, tok_b_out, exp_wr, exp_a, exp_b);
    end
  endtask

  function automatic logic [N-1:0] bit_at(input int p);
    return N'(1) << p;
  endfunction

  // Arm from the input-side port, then fill the whole row with a gap pattern.
  task automatic full_load(input logic fwd, input string req);
    dir_fwd = fwd;
    cyc(fwd, !fwd, 1'b1, 1'b0);
    chk(req, '0, 1'b0, 1'b0);
    for (int i = 0; i < N; i++) begin
      if (i == 3) begin
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 gap", '0, 1'b0, 1'b0);
      end
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      chk(req, bit_at(fwd ? i : N - 1 - i),
          (!fwd) && (i == N - 1), fwd && (i == N - 1));
    end
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R5 standby", '0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk("R1 in reset", '0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 after reset", '0, 1'b0, 1'b0);

    // R7 output enables follow the direction select
    dir_fwd = 1'b1; #1; n_run++;
    if (tok_b_oe !== 1'b1 || tok_a_oe !== 1'b0) begin
      n_fail++; $display("FAIL R7: oe a=%b b=%b expected a=0 b=1", tok_a_oe, tok_b_oe);
    end
    dir_fwd = 1'b0; #1; n_run++;
    if (tok_a_oe !== 1'b1 || tok_b_oe !== 1'b0) begin
      n_fail++; $display("FAIL R7: oe a=%b b=%b expected a=1 b=0", tok_a_oe, tok_b_oe);
    end

    full_load(1'b1, "R2 R3 R6 fwd");
    full_load(1'b0, "R2 R4 R6 rev");
    full_load(1'b1, "R5 rearm fwd");

    // R7: a token on the output-side port is ignored
    dir_fwd = 1'b1;
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 wrong port", '0, 1'b0, 1'b0);

    // R9: held token arms once
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b0);
      chk("R9 held token", bit_at(i), 1'b0, 1'b0);
    end
    // R9: fresh rise during loading restarts
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 restart", bit_at(0), 1'b0, 1'b0);

    // R8: latch rise clears loading
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 latch same cycle", bit_at(1), 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 cleared", '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 still standby", '0, 1'b0, 1'b0);
    // R8: latch wins over a simultaneous token
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 priority", '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 priority hold", '0, 1'b0, 1'b0);

    // R11: direction change mid-load keeps the captured order
    dir_fwd = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R11 first", bit_at(0), 1'b0, 1'b0);
    dir_fwd = 1'b0;
    for (int i = 1; i < 4; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R11 order kept", bit_at(i), 1'b0, 1'b0);
    end

    // R10: only one enable ever set during a fresh reverse fill
    dir_fwd = 1'b0;
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < N; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      n_run++;
      if ($countones(wr_en) != 1) begin
        n_fail++;
        $display("FAIL R10: wr_en=%b expected one bit", wr_en);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule